// File: doc/BRIEF.md
# Buffered UART Baud Rate Generator

This block is the baud-rate source for a serial interface. It divides the bus clock by a 13-bit modulo divisor. It emits a one-cycle oversample tick once every divisor bus clocks, which is sixteen times the line rate. It also emits a one-per-bit tick on every sixteenth oversample tick. Software programs the divisor through two byte-wide registers on a simple bus that has a write strobe, a one-bit register select and a combinational read-back.

The upper divisor bits are held in a side buffer until the lower byte is written. The whole 13-bit working divisor then changes at once, so software never runs on a half-updated rate. The upper register also carries two interrupt-enable bits. These act as soon as they are written and are brought out as plain outputs for the serial block's interrupt logic. A divisor of zero shuts the divider down to save power. The divider runs only while the receiver-enable or transmitter-enable input is high.

A small state machine in `ubrg_ctrl` gates the divider. It has four states:
- GEN_ARMED: the state after reset, before either enable has been seen.
- GEN_RUN: enabled with a non-zero divisor.
- GEN_HALT: enabled, but the divisor is zero.
- GEN_OFF: was enabled before, and both enables are now low.

Transitions:
- Any state goes to GEN_RUN when an enable is high and the coming divisor is non-zero.
- Any state goes to GEN_HALT when an enable is high and the coming divisor is zero.
- GEN_ARMED stays in GEN_ARMED while both enables are low.
- Every other state falls to GEN_OFF while both enables are low.

Only GEN_RUN lets the counters advance. All other states hold both counters at zero.

Top module: `ubrg_top`

## Requirements
- R1: The divisor is 13 bits. Bits 12:8 are at bits 4:0 of the high register (select 0), and bits 7:0 are the low register (select 1). Bit 5 of the high register always reads 0.
- R2: A write to the high register changes only the side buffer. A later write to the low register loads the working divisor from {buffer, written byte}.
- R3: While the working divisor is 0, no oversample tick and no bit tick is produced.
- R4: With a working divisor BR from 1 to 8191 and the generator running, the oversample tick fires exactly once every BR bus clocks.
- R5: After reset the high register reads 0x00 and the low register reads 0x04. No tick appears until an enable input is asserted.
- R6: Once both enable inputs are low, ticks stop and both counters clear. Running resumes one cycle after an enable goes high again.
- R7: High-register bit 7 drives the break-detect interrupt enable and bit 6 drives the edge interrupt enable. Both take effect in the cycle after the write, without a low-byte write.
- R8: A low-byte write reloads the prescale counter. The first tick on the new divisor comes in the BR-th cycle after the write edge.
- R9: The bit tick fires together with every 16th oversample tick, counted from the point the generator started running.
- R10: Reading the high register returns the working divisor bits, not the pending buffered value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_sel | input | 1 | Register select: 0 high, 1 low |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| ie_brk | output | 1 | Break-detect interrupt enable bit |
| ie_edge | output | 1 | Receive active-edge interrupt enable bit |
| os_tick | output | 1 | Oversample tick, 16 per bit |
| bit_tick | output | 1 | One tick per bit period |

## Verification
The assertions are checked on every cycle. They check that no tick leaves the block unless the controller is in GEN_RUN, and that a zero divisor is never in GEN_RUN. They also check that two ticks are never adjacent when BR exceeds 1 and no reload occurs, that a bit tick always coincides with an oversample tick, and that a high-byte write leaves the working divisor untouched. Only the bench scenarios can show the exact tick spacing for a given divisor, the reload latency after a low-byte write, the read-back of working versus buffered bits, and the resume after a disable. The bench compares every cycle of ticks against a bench-side model under random register writes and enable toggles.

// File: rtl/ubrg_pkg.sv
package ubrg_pkg;
    typedef enum logic [1:0] {
        GEN_ARMED = 2'd0,
        GEN_RUN   = 2'd1,
        GEN_HALT  = 2'd2,
        GEN_OFF   = 2'd3
    } gen_state_t;

    localparam logic SEL_HI = 1'b0;
    localparam logic SEL_LO = 1'b1;
endpackage

// File: rtl/ubrg_regs.sv
module ubrg_regs
    import ubrg_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int BYTE_W = 8,
    parameter logic [BYTE_W-1:0] RST_LO = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [DIV_W-1:0]  br,
    output logic [DIV_W-1:0]  br_nxt,
    output logic              load,
    output logic              ie_brk,
    output logic              ie_edge
);
    localparam int HI_W = DIV_W - BYTE_W;
    localparam int PAD_W = BYTE_W - 2 - HI_W;

    logic [HI_W-1:0]  hi_buf_q;
    logic [DIV_W-1:0] work_q;
    logic             ieb_q;
    logic             iee_q;
    logic             hi_wr;
    logic             lo_wr;

    always_comb begin
        hi_wr  = we && (sel == SEL_HI);
        lo_wr  = we && (sel == SEL_LO);
        load   = lo_wr;
        br_nxt = lo_wr ? {hi_buf_q, wdata} : work_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_buf_q <= '0;
            work_q   <= {{HI_W{1'b0}}, RST_LO};
            ieb_q    <= 1'b0;
            iee_q    <= 1'b0;
        end else begin
            if (hi_wr) begin
                hi_buf_q <= wdata[HI_W-1:0];
                ieb_q    <= wdata[BYTE_W-1];
                iee_q    <= wdata[BYTE_W-2];
            end
            if (lo_wr) begin
                work_q <= br_nxt;
            end
        end
    end

    always_comb begin
        if (sel == SEL_HI) begin
            rdata = {ieb_q, iee_q, {PAD_W{1'b0}}, work_q[DIV_W-1:BYTE_W]};
        end else begin
            rdata = work_q[BYTE_W-1:0];
        end
    end

    assign br      = work_q;
    assign ie_brk  = ieb_q;
    assign ie_edge = iee_q;

    // R2: a high-byte write alone never moves the working divisor
    a_r2_hi_buffered: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr |=> $stable(work_q));
    // R1: the low byte of the working divisor takes the written byte
    a_r1_lo_lands: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (work_q[BYTE_W-1:0] == $past(wdata)));
endmodule

// File: rtl/ubrg_ctrl.sv
module ubrg_ctrl
    import ubrg_pkg::*;
#(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] br,
    input  logic [DIV_W-1:0] br_nxt,
    output logic             run
);
    gen_state_t state_q;
    gen_state_t state_d;
    logic       any_en;

    always_comb begin
        any_en  = rx_en || tx_en;
        state_d = state_q;
        unique case (state_q)
            GEN_ARMED: begin
                if (any_en) state_d = (br_nxt == '0) ? GEN_HALT : GEN_RUN;
            end
            GEN_RUN, GEN_HALT, GEN_OFF: begin
                if (!any_en)             state_d = GEN_OFF;
                else if (br_nxt == '0)   state_d = GEN_HALT;
                else                     state_d = GEN_RUN;
            end
            default: state_d = GEN_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        run = (state_q == GEN_RUN);
    end

    // R3: the run state never coexists with a zero divisor
    a_r3_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GEN_RUN) |-> (br != '0));
    // R5: leaving the armed state requires an enable
    a_r5_armed_waits: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == GEN_ARMED) && !rx_en && !tx_en) |=> (state_q == GEN_ARMED));
endmodule

// File: rtl/ubrg_div.sv
module ubrg_div #(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] br,
    output logic             os_tick,
    output logic             bit_tick
);
    localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [OVS_W-1:0] OVS_TOP = OVS_W'(OVS - 1);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [OVS_W-1:0] sub_q;
    logic             hit;

    always_comb begin
        hit      = run && (cnt_q == (br - ONE));
        os_tick  = hit;
        bit_tick = hit && (sub_q == OVS_TOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || !run || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q <= '0;
        end else if (!run) begin
            sub_q <= '0;
        end else if (hit) begin
            sub_q <= (sub_q == OVS_TOP) ? '0 : sub_q + OVS_W'(1);
        end
    end

    // R9: a bit tick is always one of the oversample ticks
    a_r9_bit_in_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
    // R4: ticks are spaced by BR cycles, so never adjacent when BR exceeds 1
    a_r4_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        (os_tick && (br > ONE) && !load) |=> !os_tick);
endmodule

// File: rtl/ubrg_top.sv
module ubrg_top
    import ubrg_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int BYTE_W = 8,
    parameter int OVS    = 16,
    parameter logic [BYTE_W-1:0] RST_LO = 8'h04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rx_en,
    input  logic              tx_en,
    output logic              ie_brk,
    output logic              ie_edge,
    output logic              os_tick,
    output logic              bit_tick
);
    logic [DIV_W-1:0] br;
    logic [DIV_W-1:0] br_nxt;
    logic             load;
    logic             run;

    ubrg_regs #(.DIV_W(DIV_W), .BYTE_W(BYTE_W), .RST_LO(RST_LO)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .sel(bus_sel),
        .wdata(bus_wdata), .rdata(bus_rdata), .br(br), .br_nxt(br_nxt),
        .load(load), .ie_brk(ie_brk), .ie_edge(ie_edge)
    );

    ubrg_ctrl #(.DIV_W(DIV_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .br(br), .br_nxt(br_nxt), .run(run)
    );

    ubrg_div #(.DIV_W(DIV_W), .OVS(OVS)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .load(load), .br(br),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    // R6: no tick leaves the block unless the controller runs
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!os_tick && !bit_tick));
    // R3: zero divisor is silent
    a_r3_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (br == '0) |-> !os_tick);
endmodule

// File: tb/ubrg_top_tb.sv
module ubrg_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       rx_en = 1'b0;
    logic       tx_en = 1'b0;
    logic       ie_brk, ie_edge, os_tick, bit_tick;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state
    logic [12:0] m_work = 13'h004;
    logic [4:0]  m_buf = 5'h00;
    logic        m_ieb = 1'b0, m_iee = 1'b0, m_enq = 1'b0;
    logic [12:0] m_cnt = 13'h0;
    logic [3:0]  m_sub = 4'h0;

    always #4 clk = ~clk;

    ubrg_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_en(rx_en),
        .tx_en(tx_en), .ie_brk(ie_brk), .ie_edge(ie_edge),
        .os_tick(os_tick), .bit_tick(bit_tick)
    );

    function automatic logic exp_os();
        return m_enq && (m_work != 13'd0) && (m_cnt == m_work - 13'd1);
    endfunction

    function automatic logic exp_bit();
        return exp_os() && (m_sub == 4'd15);
    endfunction

    function automatic logic [7:0] exp_hi();
        return {m_ieb, m_iee, 1'b0, m_work[12:8]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model advance at each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_work = 13'h004; m_buf = 5'h0; m_ieb = 1'b0; m_iee = 1'b0;
            m_enq = 1'b0; m_cnt = 13'h0; m_sub = 4'h0;
        end else begin
            logic act, hit, ld;
            act = m_enq && (m_work != 13'd0);
            hit = exp_os();
            ld  = bus_we && bus_sel;
            if (ld || !act || hit) m_cnt = 13'h0;
            else m_cnt = m_cnt + 13'd1;
            if (!act) m_sub = 4'h0;
            else if (hit) m_sub = m_sub + 4'd1;
            if (bus_we && !bus_sel) begin
                m_buf = bus_wdata[4:0];
                m_ieb = bus_wdata[7];
                m_iee = bus_wdata[6];
            end
            if (ld) m_work = {m_buf, bus_wdata};
            m_enq = rx_en || tx_en;
        end
    end

    // per-cycle tick comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 os_tick vs model", int'(os_tick), int'(exp_os()));
            chk("R9 bit_tick vs model", int'(bit_tick), int'(exp_bit()));
        end
    end

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
        @(negedge clk); #1;
        bus_sel = sel;
        #1;
        chk(tag, int'(bus_rdata), int'(exp));
    endtask

    task automatic window(input int n, output int os_n, output int bit_n);
        os_n = 0; bit_n = 0;
        repeat (n) begin
            @(negedge clk);
            os_n += int'(os_tick);
            bit_n += int'(bit_tick);
        end
    endtask

    task automatic set_en(input logic r, input logic t);
        @(negedge clk); #1;
        rx_en = r; tx_en = t;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int o, b, k;
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R5: reset values and idle before enable
        rd(1'b0, 8'h00, "R5 high reset");
        rd(1'b1, 8'h04, "R5 low reset");
        window(30, o, b);
        chk("R5 no tick before enable", o, 0);

        // R4: steady BR=4
        set_en(1'b0, 1'b1);
        window(10, o, b);
        window(40, o, b);
        chk("R4 ticks in 40 cycles at BR=4", o, 10);

        // R2/R10: buffered high byte
        wr(1'b0, 8'h01);
        rd(1'b0, 8'h00, "R10 high reads working bits");
        window(40, o, b);
        chk("R2 rate unchanged after high write", o, 10);
        wr(1'b1, 8'h00);
        rd(1'b0, 8'h01, "R2 high bits committed by low write");
        rd(1'b1, 8'h00, "R1 low bits committed");

        // R8: reload latency with BR=5
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h05);
        k = 1;
        while (!os_tick && k < 20) begin
            @(negedge clk);
            k++;
        end
        chk("R8 first tick cycle after reload", k, 5);

        // R3: zero divisor
        wr(1'b1, 8'h00);
        window(100, o, b);
        chk("R3 no ticks at BR=0", o, 0);

        // R9: BR=1, bit tick every 16
        wr(1'b1, 8'h01);
        window(4, o, b);
        window(64, o, b);
        chk("R4 BR=1 every cycle", o, 64);
        chk("R9 bit ticks in 64 cycles", b, 4);

        // R6: disable stops ticks, resume
        set_en(1'b0, 1'b0);
        window(2, o, b);
        window(50, o, b);
        chk("R6 no ticks when disabled", o + b, 0);
        set_en(1'b1, 1'b0);
        window(3, o, b);
        window(32, o, b);
        chk("R6 resumed by receiver enable", o, 32);
        chk("R6 bit counter cleared on disable", b, 2);

        // R7/R1: interrupt enables and bit 5
        wr(1'b0, 8'hE0);
        chk("R7 break enable", int'(ie_brk), 1);
        chk("R7 edge enable", int'(ie_edge), 1);
        rd(1'b0, 8'hC0, "R1 bit5 reads zero, R7 bits read back");
        rd(1'b1, 8'h01, "R7 low untouched by high write");
        wr(1'b0, 8'h40);
        chk("R7 break enable cleared", int'(ie_brk), 0);

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 6);
            case (op)
                0: begin
                    d = 8'($urandom_range(0, 255));
                    if ($urandom_range(0, 3) != 0) d[4:0] = 5'h0;
                    wr(1'b0, d);
                end
                1, 2: wr(1'b1, 8'($urandom_range(0, 24)));
                3: set_en(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
                4: rd(1'b0, exp_hi(), "R10 random high read");
                5: rd(1'b1, m_work[7:0], "R1 random low read");
                default: window($urandom_range(1, 60), o, b);
            endcase
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule